// File: doc/BRIEF.md
# Gated Device Clock Generator

This block derives the clock that a controller drives out to an external peripheral from a faster system clock. The rate comes from a half-period count that software or a bring-up sequencer may rewrite at any time. A typical link starts near 400 kHz and later moves to tens of MHz. A new count is taken only at a period boundary, while the output is low, so the pin never carries a shortened pulse. A framing state machine also drives a select output around each burst. It holds the clock low for one full period after select goes active, and for two full periods after the last pulse before select is released.

The framing machine has five states. `ST_IDLE` leaves select inactive. `ST_LEAD` is the quiet period after select goes active. `ST_RUN` produces one full clock pulse per period. `ST_PAUSE` parks the clock low while select stays active. `ST_TRAIL` holds select active for the closing quiet periods. The machine moves only at period boundaries. On `req_i`, `ST_IDLE` goes to `ST_LEAD`. When the lead count is done, `ST_LEAD` takes the common decision, and `ST_RUN` and `ST_PAUSE` take it at every boundary. The decision is: `ST_TRAIL` if `req_i` is low, else `ST_PAUSE` if `hold_i` is high, else `ST_RUN`. When the trail count is done, `ST_TRAIL` returns to `ST_IDLE`. A stop therefore always lands on a period edge with the output low, and a restart begins with a full-width high phase.

The output can be shaped three ways. In single-rate mode the clock rises at the start of each period, falls at its middle, and data is launched on the falling edge. In shifted double-rate mode the clock is delayed by a quarter period, so that each edge sits in the middle of a data window that changes at every half-period boundary. If the half-period count cannot be split into quarters, double-rate falls back to edge-aligned output and raises a flag. One-cycle strobes tell the data path when the clock is about to rise or fall and when to launch new data.

Top module: `devclk_gen`

## Requirements
- R1: While `rst_n` is low, `dev_clk_o`, `sel_o`, `running_o`, `shift_bad_o` and all three strobes are 0.
- R2: A half period lasts `half_cnt_i`+1 system cycles, so one output period is 2·(`half_cnt_i`+1) cycles; a value of 0 gives a period of 2 cycles.
- R3: `half_cnt_i` and `ddr_i` are sampled only at a period boundary, where the output is low. Every high and low phase of `dev_clk_o` has the full length of the setting in force for that period.
- R4: `sel_o` rises at a period boundary after `req_i` is seen there. The first rising edge of `dev_clk_o` follows exactly one full period (2·(`half_cnt_i`+1) cycles) later, and `dev_clk_o` is never high while `sel_o` is low.
- R5: When `req_i` is seen low at a boundary, no more pulses are produced. `sel_o` stays high for two more full periods and then falls. In single-rate mode `sel_o` falls 5·(`half_cnt_i`+1) cycles after the last falling edge.
- R6: `hold_i` seen high at a boundary parks `dev_clk_o` low from that boundary on, with `sel_o` kept high. `running_o` stays high until the parked period begins. A restart begins with a high phase of full length.
- R7: With `ddr_i`=0, the clock is high in the first half of each running period. `upd_stb_o` equals `fall_stb_o`, so data changes on the falling edge and is sampled on the rising edge, which follows `half_cnt_i`+2 sampled cycles after the strobe.
- R8: With `ddr_i`=1 and `half_cnt_i` odd (bit 0 set), the clock rises (`half_cnt_i`+1)/2 cycles into the period and falls the same distance into the second half. `upd_stb_o` pulses in the last cycle of each half period of a running period, and `shift_bad_o` is 0.
- R9: With `ddr_i`=1 and `half_cnt_i` even, the clock is edge-aligned as in R7, `upd_stb_o` pulses before both edges, and `shift_bad_o` is 1.
- R10: `rise_stb_o` (`fall_stb_o`) is high exactly in the cycle before `dev_clk_o` goes from 0 to 1 (1 to 0). The two never coincide, and no strobe fires outside a framed burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_cnt_i | input | DIV_W | Half-period length minus one, in system cycles |
| ddr_i | input | 1 | Request double-rate (quarter-shifted) output |
| req_i | input | 1 | Transfer pending; frames a burst while high |
| hold_i | input | 1 | Consumer cannot accept data; park the clock |
| dev_clk_o | output | 1 | Device clock level (registered) |
| sel_o | output | 1 | Burst select, high from lead to end of trail |
| running_o | output | 1 | High during periods that carry a clock pulse |
| rise_stb_o | output | 1 | Cycle before `dev_clk_o` rises |
| fall_stb_o | output | 1 | Cycle before `dev_clk_o` falls |
| upd_stb_o | output | 1 | Launch next data word at the coming edge |
| shift_bad_o | output | 1 | Double-rate asked with a count that cannot be quartered |

## Verification
The hardest situations to reach are the ones where two slow things meet at one period edge. One is a rate change landing on the boundary where a shifted double-rate period hands over to an edge-aligned one. The other is a hold that arrives while a pulse is half done. The stimulus changes `half_cnt_i`, `ddr_i` and `hold_i` in the middle of running bursts, at cycles unrelated to the current phase. This leaves the boundary sampling to pick the period in which each change applies. The per-cycle model then exposes any runt phase, late stop or misplaced strobe at that handover.

// File: rtl/devclk_pkg.sv
package devclk_pkg;

    // Framing states of the burst sequencer
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_RUN   = 3'd2,
        ST_PAUSE = 3'd3,
        ST_TRAIL = 3'd4
    } frame_st_e;

    // Output shaping variants
    typedef enum logic [1:0] {
        MD_SINGLE = 2'd0,
        MD_SHIFT  = 2'd1,
        MD_EDGE   = 2'd2
    } wave_md_e;

endpackage

// File: rtl/devclk_tick.sv
// Half-period timebase: counter, phase and boundary-latched settings.
module devclk_tick #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_cnt_i,
    input  logic             ddr_i,
    output logic             tick_o,
    output logic             bnd_o,
    output logic             ph_o,
    output logic [DIV_W-1:0] hcnt_n_o,
    output logic             ph_n_o,
    output logic [DIV_W-1:0] div_n_o,
    output logic             ddr_n_o,
    output logic             shift_n_o
);

    // ph = 0 : first (high) half of a period, ph = 1 : second (low) half
    logic [DIV_W-1:0] hcnt_q, div_q;
    logic             ph_q, ddr_q, shift_q;

    always_comb begin
        tick_o    = (hcnt_q == div_q);
        bnd_o     = tick_o & ph_q;
        hcnt_n_o  = tick_o ? '0 : hcnt_q + DIV_W'(1);
        ph_n_o    = tick_o ? ~ph_q : ph_q;
        div_n_o   = bnd_o ? half_cnt_i : div_q;
        ddr_n_o   = bnd_o ? ddr_i : ddr_q;
        shift_n_o = bnd_o ? (ddr_i & half_cnt_i[0]) : shift_q;
        ph_o      = ph_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q  <= '0;
            ph_q    <= 1'b1;
            div_q   <= '0;
            ddr_q   <= 1'b0;
            shift_q <= 1'b0;
        end else begin
            hcnt_q  <= hcnt_n_o;
            ph_q    <= ph_n_o;
            div_q   <= div_n_o;
            ddr_q   <= ddr_n_o;
            shift_q <= shift_n_o;
        end
    end

endmodule

// File: rtl/devclk_fsm.sv
// Burst framing sequencer; moves only at period boundaries.
module devclk_fsm
    import devclk_pkg::*;
#(
    parameter int LEAD_P  = 1,
    parameter int TRAIL_P = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bnd_i,
    input  logic      req_i,
    input  logic      hold_i,
    output frame_st_e st_q_o,
    output frame_st_e st_d_o
);

    localparam int PC_MAX = (LEAD_P > TRAIL_P) ? LEAD_P : TRAIL_P;
    localparam int PC_W   = $clog2(PC_MAX + 1);
    localparam logic [PC_W-1:0] LEAD_LAST  = PC_W'(LEAD_P - 1);
    localparam logic [PC_W-1:0] TRAIL_LAST = PC_W'(TRAIL_P - 1);

    frame_st_e       st_q, st_d, pick;
    logic [PC_W-1:0] pc_q, pc_d;

    always_comb begin
        if (!req_i)      pick = ST_TRAIL;
        else if (hold_i) pick = ST_PAUSE;
        else             pick = ST_RUN;
    end

    always_comb begin
        st_d = st_q;
        pc_d = pc_q;
        if (bnd_i) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_i) begin
                        st_d = ST_LEAD;
                        pc_d = '0;
                    end
                end
                ST_LEAD: begin
                    if (pc_q == LEAD_LAST) begin
                        st_d = pick;
                        pc_d = '0;
                    end else begin
                        pc_d = pc_q + PC_W'(1);
                    end
                end
                ST_RUN, ST_PAUSE: begin
                    st_d = pick;
                    pc_d = '0;
                end
                ST_TRAIL: begin
                    if (pc_q == TRAIL_LAST) begin
                        st_d = ST_IDLE;
                        pc_d = '0;
                    end else begin
                        pc_d = pc_q + PC_W'(1);
                    end
                end
                default: begin
                    st_d = ST_IDLE;
                    pc_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            pc_q <= '0;
        end else begin
            st_q <= st_d;
            pc_q <= pc_d;
        end
    end

    assign st_q_o = st_q;
    assign st_d_o = st_d;

endmodule

// File: rtl/devclk_wave.sv
// Output shaping, registered pin levels and data-path strobes.
module devclk_wave
    import devclk_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ph_i,
    input  logic             run_q_i,
    input  logic             run_n_i,
    input  logic             sel_n_i,
    input  logic [DIV_W-1:0] hcnt_n_i,
    input  logic             ph_n_i,
    input  logic [DIV_W-1:0] div_n_i,
    input  logic             ddr_n_i,
    input  logic             shift_n_i,
    output logic             dev_clk_o,
    output logic             sel_o,
    output logic             running_o,
    output logic             rise_stb_o,
    output logic             fall_stb_o,
    output logic             upd_stb_o,
    output logic             shift_bad_o
);

    localparam int QW = DIV_W + 1;

    wave_md_e        md_n;
    logic [QW-1:0]   quarter_n, pos_n;
    logic            clk_n, clk_q, upd_shift;
    logic            sel_q, run_q, bad_q;

    always_comb begin
        if (!ddr_n_i)       md_n = MD_SINGLE;
        else if (shift_n_i) md_n = MD_SHIFT;
        else                md_n = MD_EDGE;
    end

    always_comb begin
        quarter_n = ({1'b0, div_n_i} + QW'(1)) >> 1;
        pos_n     = {1'b0, hcnt_n_i};
        clk_n     = 1'b0;
        if (run_n_i) begin
            unique case (md_n)
                MD_SHIFT:  clk_n = ph_n_i ? (pos_n < quarter_n) : (pos_n >= quarter_n);
                MD_SINGLE,
                MD_EDGE:   clk_n = ~ph_n_i;
                default:   clk_n = 1'b0;
            endcase
        end
    end

    always_comb begin
        rise_stb_o = ~clk_q & clk_n;
        fall_stb_o = clk_q & ~clk_n;
        // in shifted mode data launches at every half boundary of a running period
        upd_shift  = tick_i & (ph_i ? run_n_i : run_q_i);
        unique case (md_n)
            MD_SHIFT:  upd_stb_o = upd_shift;
            MD_EDGE:   upd_stb_o = rise_stb_o | fall_stb_o;
            MD_SINGLE: upd_stb_o = fall_stb_o;
            default:   upd_stb_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            sel_q <= 1'b0;
            run_q <= 1'b0;
            bad_q <= 1'b0;
        end else begin
            clk_q <= clk_n;
            sel_q <= sel_n_i;
            run_q <= run_n_i;
            bad_q <= ddr_n_i & ~shift_n_i;
        end
    end

    assign dev_clk_o   = clk_q;
    assign sel_o       = sel_q;
    assign running_o   = run_q;
    assign shift_bad_o = bad_q;

endmodule

// File: rtl/devclk_gen.sv
// Gated, run-time programmable device clock generator (top).
module devclk_gen
    import devclk_pkg::*;
#(
    parameter int DIV_W   = 10,
    parameter int LEAD_P  = 1,
    parameter int TRAIL_P = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_cnt_i,
    input  logic             ddr_i,
    input  logic             req_i,
    input  logic             hold_i,
    output logic             dev_clk_o,
    output logic             sel_o,
    output logic             running_o,
    output logic             rise_stb_o,
    output logic             fall_stb_o,
    output logic             upd_stb_o,
    output logic             shift_bad_o
);

    logic             tick, bnd, ph;
    logic [DIV_W-1:0] hcnt_n, div_n;
    logic             ph_n, ddr_n, shift_n;
    frame_st_e        st_q, st_d;
    logic             run_q, run_n, sel_n;

    devclk_tick #(.DIV_W(DIV_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_cnt_i(half_cnt_i),
        .ddr_i     (ddr_i),
        .tick_o    (tick),
        .bnd_o     (bnd),
        .ph_o      (ph),
        .hcnt_n_o  (hcnt_n),
        .ph_n_o    (ph_n),
        .div_n_o   (div_n),
        .ddr_n_o   (ddr_n),
        .shift_n_o (shift_n)
    );

    devclk_fsm #(.LEAD_P(LEAD_P), .TRAIL_P(TRAIL_P)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .bnd_i (bnd),
        .req_i (req_i),
        .hold_i(hold_i),
        .st_q_o(st_q),
        .st_d_o(st_d)
    );

    assign run_q = (st_q == ST_RUN);
    assign run_n = (st_d == ST_RUN);
    assign sel_n = (st_d != ST_IDLE);

    devclk_wave #(.DIV_W(DIV_W)) u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .ph_i       (ph),
        .run_q_i    (run_q),
        .run_n_i    (run_n),
        .sel_n_i    (sel_n),
        .hcnt_n_i   (hcnt_n),
        .ph_n_i     (ph_n),
        .div_n_i    (div_n),
        .ddr_n_i    (ddr_n),
        .shift_n_i  (shift_n),
        .dev_clk_o  (dev_clk_o),
        .sel_o      (sel_o),
        .running_o  (running_o),
        .rise_stb_o (rise_stb_o),
        .fall_stb_o (fall_stb_o),
        .upd_stb_o  (upd_stb_o),
        .shift_bad_o(shift_bad_o)
    );

endmodule

// File: rtl/devclk_gen_chk.sv
// Port-level properties of the device clock generator.
module devclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic dev_clk_o,
    input logic sel_o,
    input logic running_o,
    input logic rise_stb_o,
    input logic fall_stb_o,
    input logic upd_stb_o
);

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rise_stb_o && fall_stb_o)); // R10
    AST_RISE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) rise_stb_o |=> dev_clk_o); // R10
    AST_FALL_LANDS: assert property (@(posedge clk) disable iff (!rst_n) fall_stb_o |=> !dev_clk_o); // R10
    AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) dev_clk_o |-> sel_o); // R4
    AST_CLK_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n) dev_clk_o |-> running_o); // R6
    AST_TRAIL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(dev_clk_o) |-> sel_o); // R5
    AST_UPD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) upd_stb_o |-> sel_o); // R7

endmodule

bind devclk_gen devclk_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_clk_o (dev_clk_o),
    .sel_o     (sel_o),
    .running_o (running_o),
    .rise_stb_o(rise_stb_o),
    .fall_stb_o(fall_stb_o),
    .upd_stb_o (upd_stb_o)
);

// File: tb/devclk_gen_tb.sv
`timescale 1ns/1ps
module devclk_gen_tb;

    localparam int DW    = 10;
    localparam int LEAD  = 1;
    localparam int TRAIL = 2;

    logic          clk    = 1'b0;
    logic          rst_n  = 1'b0;
    logic [DW-1:0] half_r = '0;
    logic          ddr_r  = 1'b0;
    logic          req_r  = 1'b0;
    logic          hold_r = 1'b0;
    logic dev_clk_o, sel_o, running_o, rise_stb_o, fall_stb_o, upd_stb_o, shift_bad_o;

    devclk_gen #(.DIV_W(DW), .LEAD_P(LEAD), .TRAIL_P(TRAIL)) u_dut (
        .clk(clk), .rst_n(rst_n), .half_cnt_i(half_r), .ddr_i(ddr_r),
        .req_i(req_r), .hold_i(hold_r), .dev_clk_o(dev_clk_o), .sel_o(sel_o),
        .running_o(running_o), .rise_stb_o(rise_stb_o), .fall_stb_o(fall_stb_o),
        .upd_stb_o(upd_stb_o), .shift_bad_o(shift_bad_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // behavioural reference state (0 idle,1 lead,2 run,3 pause,4 trail)
    int m_h = 0, m_ph = 1, m_div = 0, m_ddr = 0, m_sh = 0, m_st = 0, m_pc = 0;
    int m_clk = 0, m_sel = 0, m_run = 0, m_bad = 0;
    int x_h, x_ph, x_div, x_ddr, x_sh, x_st, x_pc, x_clk;

    // edge monitors
    int n = 0, p_clk = 0, p_sel = 0, await_rise = 0;
    int last_rise = -1, last_fall = -1, last_upd = -1, t_sel_up = -1;
    int last_per = -1, hi_len = -1, ur_gap = -1, lead_gap = -1, trail_gap = -1, rises = 0;

    task chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task cyc();
        int tick, bnd, pick, q, e_rise, e_fall, e_upd;
        @(negedge clk);
        tick  = (m_h == m_div);
        bnd   = tick && (m_ph == 1);
        x_h   = tick ? 0 : m_h + 1;
        x_ph  = tick ? 1 - m_ph : m_ph;
        x_div = m_div; x_ddr = m_ddr; x_sh = m_sh;
        if (bnd) begin
            x_div = int'(half_r);
            x_ddr = int'(ddr_r);
            x_sh  = (ddr_r && (half_r % 2 == 1)) ? 1 : 0;
        end
        pick = !req_r ? 4 : (hold_r ? 3 : 2);
        x_st = m_st; x_pc = m_pc;
        if (bnd) begin
            if (m_st == 0) begin
                if (req_r) begin x_st = 1; x_pc = 0; end
            end else if (m_st == 1) begin
                if (m_pc == LEAD - 1) begin x_st = pick; x_pc = 0; end else x_pc = m_pc + 1;
            end else if (m_st == 2 || m_st == 3) begin
                x_st = pick; x_pc = 0;
            end else begin
                if (m_pc == TRAIL - 1) begin x_st = 0; x_pc = 0; end else x_pc = m_pc + 1;
            end
        end
        q = (x_div + 1) / 2;
        if (x_st != 2)     x_clk = 0;
        else if (x_sh == 1) x_clk = (x_ph == 0) ? int'(x_h >= q) : int'(x_h < q);
        else               x_clk = (x_ph == 0) ? 1 : 0;
        e_rise = (m_clk == 0 && x_clk == 1) ? 1 : 0;
        e_fall = (m_clk == 1 && x_clk == 0) ? 1 : 0;
        if (x_sh == 1)      e_upd = tick && ((m_ph == 1) ? (x_st == 2) : (m_st == 2));
        else if (x_ddr == 1) e_upd = e_rise | e_fall;
        else                e_upd = e_fall;

        chk("R3", int'(dev_clk_o), m_clk, "dev_clk_o");
        chk("R4", int'(sel_o), m_sel, "sel_o");
        chk("R6", int'(running_o), m_run, "running_o");
        chk("R9", int'(shift_bad_o), m_bad, "shift_bad_o");
        chk("R10", int'(rise_stb_o), e_rise, "rise_stb_o");
        chk("R10", int'(fall_stb_o), e_fall, "fall_stb_o");
        chk("R7", int'(upd_stb_o), e_upd, "upd_stb_o");

        if (rst_n) begin
            if (dev_clk_o && p_clk == 0) begin
                if (last_rise >= 0) last_per = n - last_rise;
                last_rise = n;
                rises++;
                ur_gap = n - last_upd;
                if (await_rise == 1) begin lead_gap = n - t_sel_up; await_rise = 0; end
            end
            if (!dev_clk_o && p_clk == 1) begin hi_len = n - last_rise; last_fall = n; end
            if (sel_o && p_sel == 0) begin t_sel_up = n; await_rise = 1; end
            if (!sel_o && p_sel == 1) trail_gap = n - last_fall;
            if (upd_stb_o) last_upd = n;
            p_clk = int'(dev_clk_o);
            p_sel = int'(sel_o);
        end

        @(posedge clk);
        if (!rst_n) begin
            m_h = 0; m_ph = 1; m_div = 0; m_ddr = 0; m_sh = 0; m_st = 0; m_pc = 0;
            m_clk = 0; m_sel = 0; m_run = 0; m_bad = 0;
        end else begin
            m_h = x_h; m_ph = x_ph; m_div = x_div; m_ddr = x_ddr; m_sh = x_sh;
            m_st = x_st; m_pc = x_pc; m_clk = x_clk;
            m_sel = (x_st != 0) ? 1 : 0;
            m_run = (x_st == 2) ? 1 : 0;
            m_bad = (x_ddr == 1 && x_sh == 0) ? 1 : 0;
        end
        #1;
        n++;
    endtask

    task run(input int k);
        for (int i = 0; i < k; i++) cyc();
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r0;
        run(3);
        // R1: quiet outputs under reset
        chk("R1", int'({dev_clk_o, sel_o, running_o, rise_stb_o, fall_stb_o, upd_stb_o, shift_bad_o}), 0, "outputs in reset");
        rst_n = 1'b1;
        run(4);

        // single rate, half period 4 cycles
        half_r = 10'd3; req_r = 1'b1;
        run(80);
        chk("R4", lead_gap, 8, "select-to-first-rise cycles");
        chk("R2", last_per, 8, "period half_cnt=3");
        chk("R3", hi_len, 4, "high phase length");
        chk("R7", ur_gap, 5, "update strobe to rise");

        // pause while consumer is full
        hold_r = 1'b1;
        run(16);
        r0 = rises;
        run(24);
        chk("R6", rises, r0, "rises while held");
        chk("R6", int'(running_o), 0, "running_o while parked");
        chk("R6", int'(sel_o), 1, "select kept while parked");
        hold_r = 1'b0;
        run(40);
        chk("R6", hi_len, 4, "restart high phase");

        // rate change mid burst
        half_r = 10'd1;
        run(40);
        chk("R3", last_per, 4, "period after run-time change");

        // close the burst
        req_r = 1'b0;
        run(60);
        chk("R5", trail_gap, 10, "last fall to select release");
        chk("R5", int'(sel_o), 0, "select released");

        // shifted double rate
        ddr_r = 1'b1; half_r = 10'd3; req_r = 1'b1;
        run(60);
        chk("R8", int'(shift_bad_o), 0, "flag in shifted mode");
        chk("R8", ur_gap, 3, "quarter delay after update");
        chk("R8", last_per, 8, "shifted period");

        // fallback: even count
        half_r = 10'd2;
        run(60);
        chk("R9", int'(shift_bad_o), 1, "flag with even count");
        chk("R9", last_per, 6, "fallback period");
        chk("R9", hi_len, 3, "fallback high phase");

        // fastest rate
        ddr_r = 1'b0; half_r = 10'd0;
        run(30);
        chk("R2", last_per, 2, "period half_cnt=0");

        // bring-up rate
        half_r = 10'd249;
        run(3000);
        chk("R2", last_per, 500, "period half_cnt=249");

        req_r = 1'b0;
        run(2600);
        chk("R5", int'(sel_o), 0, "select released at slow rate");
        chk("R5", int'(dev_clk_o), 0, "clock parked at slow rate");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule